// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the host-facing register file of a PC-style parallel port. A simple synchronous bus reaches it. The bus carries an address, write data, a write strobe, a read strobe and read data. Registers sit in two blocks. The lower block starts at address 0x000 and the upper block starts 0x400 above it.

The lower block holds five things:
- the byte that drives the data lines;
- a read-only status byte built from the peripheral's input pins;
- a control byte that drives the output control pins and the data-line direction;
- an address window for enhanced (EPP) transfers;
- four data windows for enhanced transfers.

The upper block holds the extended control byte, which selects the port mode.

An external handshake sequencer carries out the enhanced transfers. This block only hands that sequencer a one-cycle request with the byte to send. It also takes back a timeout pulse from the sequencer and keeps it as a sticky status flag.

Top module: `ppt_host_regs`

## Requirements
- R1: After reset these values hold:
  - `bus_rdata` is 0x00.
  - `pd_out` is 0x00 and `pd_oe` is 1.
  - The control byte (address 0x002) reads 0x00.
  - The extended control byte (address 0x402) reads 0x01.
  - `port_mode` is 000.
- R2: In mode 000, a write to address 0x000 places the byte on `pd_out`. `pd_oe` stays 1 whatever the direction bit holds.
- R3: In any mode other than 000, `pd_oe` is the inverse of the direction bit (control bit 5).
- R4: A read of address 0x000 returns the level on `pd_in`, not the last byte written.
- R5: A read of address 0x001 returns these bits:
  - bit 7 = NOT `pin_busy`
  - bit 6 = `pin_ack`
  - bit 5 = `pin_pe`
  - bit 4 = `pin_slct`
  - bit 3 = `pin_err`
  - bit 2 = `irq_pending`
- R6: Status bit 1 always reads 1. Outside enhanced mode (mode 100), status bit 0 reads 1.
- R7: In mode 100, a `tmo_pulse` sets a sticky flag that reads as status bit 0. A status read clears the flag, so the next read returns 0.
- R8: If `tmo_pulse` and a status read fall in the same cycle, that read returns bit 0 = 1 and the flag stays set.
- R9: The control byte stores bits 5:0 of a write and reads bits 7:6 as 0. The bits map as follows:
  - bit 4 drives `irq_en`;
  - bits 3:0 drive `ctrl_pins[3:0]`, which are select-in, init, auto-feed and strobe, in that order from bit 3 down.
- R10: The extended control byte stores write bits 7:5 as the mode and presents the mode on `port_mode`. Its bits 4:0 always read 00001.
- R11: Outside mode 100, addresses 0x003 to 0x007 read 0x00. Writes to them change nothing and raise no request.
- R12: In mode 100, a write to address 0x003 raises `epp_addr_req` for exactly one cycle, on the cycle after the write, with the byte on `epp_byte`. A write to 0x004+k (k = 0..3) raises `epp_data_req` in the same way, with k on `epp_lane`. The written value reads back from the same address.
- R13: Read data appears on `bus_rdata` on the cycle after the read strobe and holds until the next read. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (11) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pd_in | input | 8 | Level present on the data pins |
| pd_out | output | 8 | Byte to drive on the data pins |
| pd_oe | output | 1 | Data-line driver enable |
| pin_busy | input | 1 | Peripheral busy |
| pin_ack | input | 1 | Peripheral acknowledge |
| pin_pe | input | 1 | Paper empty |
| pin_slct | input | 1 | Peripheral selected |
| pin_err | input | 1 | Peripheral error |
| irq_pending | input | 1 | Interrupt-pending indication |
| ctrl_pins | output | 4 | Select-in, init, auto-feed, strobe (bit 3 down to bit 0) |
| irq_en | output | 1 | Interrupt enable bit |
| port_mode | output | 3 | Current mode field |
| tmo_pulse | input | 1 | Timeout pulse from the handshake logic |
| epp_addr_req | output | 1 | One-cycle address-transfer request |
| epp_data_req | output | 1 | One-cycle data-transfer request |
| epp_byte | output | 8 | Byte carried by a request |
| epp_lane | output | 2 | Data window index of a data request |

## Verification
The bench goes after the edges of the timeout flag:
- A pulse that lands in the same cycle as a status read must not be lost. A design that let the clear win would report 0 on the next read.
- A second read must return 0. A flag that never clears would keep returning 1.

It toggles the direction bit in both mode 000 and a non-enhanced mode. A design that gated the drivers in mode 000 would float the data lines there.

It writes the enhanced windows outside mode 100 and then reads them back inside it. A design that stored or requested on those writes shows stale bytes or spurious pulses.

It reads the data address with `pd_in` held at a value different from the last write. A design returning the written byte would fail that read.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
    localparam int DW     = 8;
    localparam int MODE_W = 3;
    localparam int CTRL_W = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);

    localparam logic [MODE_W-1:0] MODE_COMPAT = 3'b000;
    localparam logic [MODE_W-1:0] MODE_EPP    = 3'b100;
    localparam logic [4:0]        XCR_LOW     = 5'b00001;

    typedef enum logic [2:0] {
        RG_NONE, RG_DATA, RG_STAT, RG_CTRL, RG_EADDR, RG_EDATA, RG_XCR
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0]                data;
        logic [CTRL_W-1:0]            ctrl;
        logic [MODE_W-1:0]            mode;
        logic [DW-1:0]                eaddr;
        logic [LANES-1:0][DW-1:0]     edata;
        logic [DW-1:0]                rdata;
        logic                         areq;
        logic                         dreq;
        logic [DW-1:0]                ebyte;
        logic [LANE_W-1:0]            lane;
    } regs_t;
endpackage

// File: rtl/ppt_decode.sv
module ppt_decode
    import ppt_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int UPPER_BASE = 'h400
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [LANE_W-1:0] lane
);
    localparam logic [ADDR_W-1:0] XCR_ADDR = ADDR_W'(UPPER_BASE + 2);

    always_comb begin
        sel  = RG_NONE;
        lane = addr[LANE_W-1:0];
        if (addr[ADDR_W-1:3] == '0) begin
            case (addr[2:0])
                3'd0:    sel = RG_DATA;
                3'd1:    sel = RG_STAT;
                3'd2:    sel = RG_CTRL;
                3'd3:    sel = RG_EADDR;
                default: sel = RG_EDATA;
            endcase
        end else if (addr == XCR_ADDR) begin
            sel = RG_XCR;
        end
    end
endmodule

// File: rtl/ppt_status.sv
module ppt_status
    import ppt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          epp_mode,
    input  logic          rd_stat,
    input  logic          tmo_pulse,
    input  logic          pin_busy,
    input  logic          pin_ack,
    input  logic          pin_pe,
    input  logic          pin_slct,
    input  logic          pin_err,
    input  logic          irq_pending,
    output logic [DW-1:0] stat_byte
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (epp_mode && tmo_pulse)
            flag_d = 1'b1;
        else if (epp_mode && rd_stat)
            flag_d = 1'b0;

        stat_byte = {~pin_busy, pin_ack, pin_pe, pin_slct, pin_err, irq_pending,
                     1'b1, epp_mode ? (flag_q | tmo_pulse) : 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    AST_TMO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !rd_stat) |=> flag_q);                                    // R7
    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_mode && rd_stat && !tmo_pulse) |=> !flag_q);                    // R7
    AST_TMO_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_mode && rd_stat && tmo_pulse) |=> flag_q);                      // R8
endmodule

// File: rtl/ppt_host_regs.sv
module ppt_host_regs
    import ppt_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int UPPER_BASE = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     pd_in,
    output logic [DW-1:0]     pd_out,
    output logic              pd_oe,
    input  logic              pin_busy,
    input  logic              pin_ack,
    input  logic              pin_pe,
    input  logic              pin_slct,
    input  logic              pin_err,
    input  logic              irq_pending,
    output logic [3:0]        ctrl_pins,
    output logic              irq_en,
    output logic [MODE_W-1:0] port_mode,
    input  logic              tmo_pulse,
    output logic              epp_addr_req,
    output logic              epp_data_req,
    output logic [DW-1:0]     epp_byte,
    output logic [LANE_W-1:0] epp_lane
);
    regs_t             r_d, r_q;
    reg_sel_e          sel;
    logic [LANE_W-1:0] lane;
    logic [DW-1:0]     stat_byte;
    logic              epp_mode;
    logic              rd_stat;

    assign epp_mode = (r_q.mode == MODE_EPP);
    assign rd_stat  = bus_re && (sel == RG_STAT);

    ppt_decode #(.ADDR_W(ADDR_W), .UPPER_BASE(UPPER_BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .lane (lane)
    );

    ppt_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .epp_mode    (epp_mode),
        .rd_stat     (rd_stat),
        .tmo_pulse   (tmo_pulse),
        .pin_busy    (pin_busy),
        .pin_ack     (pin_ack),
        .pin_pe      (pin_pe),
        .pin_slct    (pin_slct),
        .pin_err     (pin_err),
        .irq_pending (irq_pending),
        .stat_byte   (stat_byte)
    );

    always_comb begin
        r_d      = r_q;
        r_d.areq = 1'b0;
        r_d.dreq = 1'b0;

        if (bus_re) begin
            case (sel)
                RG_DATA:  r_d.rdata = pd_in;
                RG_STAT:  r_d.rdata = stat_byte;
                RG_CTRL:  r_d.rdata = {{(DW-CTRL_W){1'b0}}, r_q.ctrl};
                RG_EADDR: r_d.rdata = epp_mode ? r_q.eaddr : '0;
                RG_EDATA: r_d.rdata = epp_mode ? r_q.edata[lane] : '0;
                RG_XCR:   r_d.rdata = {r_q.mode, XCR_LOW};
                default:  r_d.rdata = '0;
            endcase
        end

        if (bus_we) begin
            case (sel)
                RG_DATA: r_d.data = bus_wdata;
                RG_CTRL: r_d.ctrl = bus_wdata[CTRL_W-1:0];
                RG_XCR:  r_d.mode = bus_wdata[DW-1 -: MODE_W];
                RG_EADDR: if (epp_mode) begin
                    r_d.eaddr = bus_wdata;
                    r_d.areq  = 1'b1;
                    r_d.ebyte = bus_wdata;
                end
                RG_EDATA: if (epp_mode) begin
                    r_d.edata[lane] = bus_wdata;
                    r_d.dreq        = 1'b1;
                    r_d.ebyte       = bus_wdata;
                    r_d.lane        = lane;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= MODE_COMPAT;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata    = r_q.rdata;
    assign pd_out       = r_q.data;
    assign pd_oe        = (r_q.mode == MODE_COMPAT) || !r_q.ctrl[5];
    assign ctrl_pins    = r_q.ctrl[3:0];
    assign irq_en       = r_q.ctrl[4];
    assign port_mode    = r_q.mode;
    assign epp_addr_req = r_q.areq;
    assign epp_data_req = r_q.dreq;
    assign epp_byte     = r_q.ebyte;
    assign epp_lane     = r_q.lane;

    AST_COMPAT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_mode == MODE_COMPAT) |-> pd_oe);                               // R2
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({epp_addr_req, epp_data_req}));                             // R12
    AST_WIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !epp_mode && (sel == RG_EADDR || sel == RG_EDATA))
        |=> !(epp_addr_req || epp_data_req));                                // R11
    AST_XCR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && sel == RG_XCR) |=> (bus_rdata[4:0] == XCR_LOW));          // R10
    AST_STAT_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> bus_rdata[1]);                                           // R6
endmodule

// File: tb/tb_ppt_host_regs.sv
module tb_ppt_host_regs;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 0, bus_re = 0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pd_in = '0;
    logic [7:0]  pd_out;
    logic        pd_oe;
    logic        pin_busy = 0, pin_ack = 0, pin_pe = 0, pin_slct = 0, pin_err = 0;
    logic        irq_pending = 0;
    logic [3:0]  ctrl_pins;
    logic        irq_en;
    logic [2:0]  port_mode;
    logic        tmo_pulse = 0;
    logic        epp_addr_req, epp_data_req;
    logic [7:0]  epp_byte;
    logic [1:0]  epp_lane;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    ppt_host_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .pin_busy(pin_busy), .pin_ack(pin_ack), .pin_pe(pin_pe),
        .pin_slct(pin_slct), .pin_err(pin_err), .irq_pending(irq_pending),
        .ctrl_pins(ctrl_pins), .irq_en(irq_en), .port_mode(port_mode),
        .tmo_pulse(tmo_pulse), .epp_addr_req(epp_addr_req),
        .epp_data_req(epp_data_req), .epp_byte(epp_byte), .epp_lane(epp_lane)
    );

    // behavioural reference
    logic [7:0] m_data, m_eaddr, m_rd, m_byte;
    logic [5:0] m_ctrl;
    logic [2:0] m_mode;
    logic [7:0] m_ed [4];
    logic       m_areq, m_dreq, m_flag;
    logic [1:0] m_lane;

    always @(posedge clk) begin : model
        int  a;
        bit  epp;
        logic [7:0] v;
        if (!rst_n) begin
            m_data = 0; m_ctrl = 0; m_mode = 0; m_eaddr = 0; m_rd = 0;
            m_areq = 0; m_dreq = 0; m_flag = 0; m_byte = 0; m_lane = 0;
            foreach (m_ed[i]) m_ed[i] = 0;
        end else begin
            a   = int'(bus_addr);
            epp = (m_mode == 3'd4);
            if (bus_re) begin
                v = 0;
                if (a == 0) v = pd_in;
                else if (a == 1) v = {~pin_busy, pin_ack, pin_pe, pin_slct, pin_err,
                                      irq_pending, 1'b1, epp ? (m_flag | tmo_pulse) : 1'b1};
                else if (a == 2) v = {2'b00, m_ctrl};
                else if (a == 3) v = epp ? m_eaddr : 8'h00;
                else if (a >= 4 && a <= 7) v = epp ? m_ed[a-4] : 8'h00;
                else if (a == 'h402) v = {m_mode, 5'b00001};
                m_rd = v;
            end
            if (epp && tmo_pulse) m_flag = 1;
            else if (epp && bus_re && a == 1) m_flag = 0;
            m_areq = 0; m_dreq = 0;
            if (bus_we) begin
                if (a == 0) m_data = bus_wdata;
                else if (a == 2) m_ctrl = bus_wdata[5:0];
                else if (a == 'h402) m_mode = bus_wdata[7:5];
                else if (a == 3 && epp) begin
                    m_eaddr = bus_wdata; m_areq = 1; m_byte = bus_wdata;
                end else if (a >= 4 && a <= 7 && epp) begin
                    m_ed[a-4] = bus_wdata; m_dreq = 1; m_byte = bus_wdata; m_lane = 2'(a-4);
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R13 rdata", bus_rdata, m_rd);
            chk("R2 pd_out", pd_out, m_data);
            chk("R3 pd_oe", pd_oe, (m_mode == 0) || !m_ctrl[5]);
            chk("R9 ctrl_pins", {irq_en, ctrl_pins}, m_ctrl[4:0]);
            chk("R10 port_mode", port_mode, m_mode);
            chk("R12 reqs", {epp_addr_req, epp_data_req}, {m_areq, m_dreq});
            if (m_areq || m_dreq) chk("R12 byte", epp_byte, m_byte);
            if (m_dreq) chk("R12 lane", epp_lane, m_lane);
        end
    end

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk); bus_addr = 11'(a); bus_wdata = d; bus_we = 1;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(int a, output logic [7:0] d);
        @(negedge clk); bus_addr = 11'(a); bus_re = 1;
        @(negedge clk); bus_re = 0; d = bus_rdata;
    endtask

    bit done = 0;
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 pd_oe", pd_oe, 1'b1);
        chk("R1 pd_out", pd_out, 8'h00);
        rd('h402, d); chk("R1 xcr", d, 8'h01);
        rd(2, d);     chk("R1 ctrl", d, 8'h00);

        wr(0, 8'hA5); chk("R2 drive", pd_out, 8'hA5);
        wr(2, 8'h20); chk("R2 dir ignored", pd_oe, 1'b1);
        pd_in = 8'h3C;
        rd(0, d); chk("R4 pin level", d, 8'h3C);

        wr('h402, 8'h3F); chk("R3 dir set", pd_oe, 1'b0);
        rd('h402, d); chk("R10 low bits", d, 8'h21);
        wr(2, 8'h00); chk("R3 dir clear", pd_oe, 1'b1);

        pin_busy = 1; pin_ack = 1; pin_pe = 0; pin_slct = 1; pin_err = 0; irq_pending = 1;
        rd(1, d); chk("R5 R6 status", d, 8'h57);
        pin_busy = 0; pin_ack = 0; pin_pe = 1; pin_slct = 0; pin_err = 1; irq_pending = 0;
        rd(1, d); chk("R5 status2", d, 8'hAB);

        wr(3, 8'h77);
        chk("R11 no req", {epp_addr_req, epp_data_req}, 2'b00);
        wr(5, 8'h66);
        rd(3, d); chk("R11 read zero", d, 8'h00);

        wr('h402, 8'h81);
        rd(5, d); chk("R11 write ignored", d, 8'h00);
        wr(3, 8'h5A);
        chk("R12 addr req", {epp_addr_req, epp_byte}, {1'b1, 8'h5A});
        @(negedge clk); chk("R12 one cycle", epp_addr_req, 1'b0);
        wr(6, 8'hC3);
        chk("R12 data req", {epp_data_req, epp_lane, epp_byte}, {1'b1, 2'd2, 8'hC3});
        rd(6, d); chk("R12 readback", d, 8'hC3);

        rd(1, d); chk("R7 idle bit0", d[0], 1'b0);
        @(negedge clk); tmo_pulse = 1; @(negedge clk); tmo_pulse = 0;
        rd(1, d); chk("R7 set", d[0], 1'b1);
        rd(1, d); chk("R7 cleared", d[0], 1'b0);
        @(negedge clk); bus_addr = 11'd1; bus_re = 1; tmo_pulse = 1;
        @(negedge clk); bus_re = 0; tmo_pulse = 0;
        chk("R8 same-cycle read", bus_rdata[0], 1'b1);
        rd(1, d); chk("R8 kept", d[0], 1'b1);
        rd(1, d); chk("R8 then clear", d[0], 1'b0);

        wr(2, 8'hFF); rd(2, d); chk("R9 upper zero", d, 8'h3F);
        chk("R9 pins", {irq_en, ctrl_pins}, 5'h1F);
        chk("R3 epp dir", pd_oe, 1'b0);
        wr('h402, 8'h01);
        rd(1, d); chk("R6 non-epp bit0", d[1:0], 2'b11);

        rd('h010, d); chk("R13 unmapped", d, 8'h00);
        rd('h400, d); chk("R13 unmapped upper", d, 8'h00);
        @(negedge clk); chk("R13 hold", bus_rdata, 8'h00);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule